// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a host run management transactions to Ethernet PHYs over the two-wire MDIO bus. The host fills a small register file through a flat read/write port: a Clause 45 address word, a write-data word and finally a command word. The command word picks the frame type (Clause 22 or Clause 45), the operation, the PHY port address and the device or register address. Writing the command with its go bit set starts a frame, and that bit then serves as the busy flag that the host polls.

The master generates MDC from the system clock with a parameterised divider and shifts the whole frame out MSB first. The frame is a preamble of ones, the start pattern, the opcode, both address fields, the turnaround and sixteen data bits. For read operations it lets go of the line from the turnaround onward. It checks that the PHY pulls the second turnaround bit low, and it shifts the PHY's data into a read-data register. A status bit records whether the last read got no answer.

Top module: `mdio_master`

## Requirements
- R1: After reset every host register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register offsets are 0x00 command, 0x04 Clause 45 address, 0x08 write data, 0x0C read data and 0x10 status. Address and write data keep only bits 15:0 of a host write. Read data and status ignore host writes.
- R3: The command word holds the device/register address in bits 4:0, the PHY address in bits 9:5, the opcode in bits 11:10 and the frame type in bits 13:12, and bit 14 is go. A command write with bit 14 set starts a frame. Bit 14 reads 1 while the frame runs and 0 once it ends, and bits 13:0 read back as written.
- R4: A command write that arrives while bit 14 reads 1 has no effect. No second frame is sent and the stored command fields do not change.
- R5: A frame is PRE_LEN (default 32) ones, then the start pattern, then opcode bits 11:10, PHY address, device/register address, two turnaround bits and 16 data bits, all MSB first. The start pattern is 01 when type = 1 (Clause 22) and 00 when type = 0 (Clause 45).
- R6: In a Clause 45 frame with opcode 0 (address) the data field is the address register. Every other write frame sends the write-data register.
- R7: A frame is a read when opcode bit 11 is 1: Clause 22 opcode 2, and Clause 45 opcodes 2 (read with post-increment) and 3 (read). Write frames drive turnaround 10 with the output enabled throughout. Read frames keep the output enable low from the first turnaround bit to the end of the frame.
- R8: A read frame shifts the 16 bits that the PHY drives after the turnaround into the read-data register, MSB first.
- R9: At the end of each read frame, status bit 0 takes the level sampled on MDIO in the second turnaround bit, so 1 means no PHY answered. Write frames leave the status unchanged.
- R10: MDC has a period of 2*DIV_HALF system clocks. The MDIO output changes only on the clock edge where MDC falls, and MDIO input is sampled where MDC rises.
- R11: Whenever no frame is in progress the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 5 | Byte offset of the register to read or write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the register at host_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Output enable for MDIO; low releases the line |
| mdio_i | input | 1 | Sampled level of the MDIO line |

## Verification
The embedded assertions check on every cycle the following: MDC toggles only at divider terminal counts, the MDIO output never changes except where MDC falls, the line is released when idle and in the turnaround and data of reads, and a command written while busy leaves the stored fields untouched. Only the bench's scenarios can show the content of a frame. That covers the preamble, the start pattern for each frame type, the choice between address and write data as payload, the captured read data, and the way the status bit follows answered and unanswered reads while writes leave it alone. These come from a behavioural PHY responder that records each bit on MDC rising edges and answers reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   // host register byte offsets
   localparam int          REG_AW  = 5;
   localparam logic [4:0]  OFS_CMD = 5'h00;
   localparam logic [4:0]  OFS_ADR = 5'h04;
   localparam logic [4:0]  OFS_WDT = 5'h08;
   localparam logic [4:0]  OFS_RDT = 5'h0C;
   localparam logic [4:0]  OFS_STS = 5'h10;

   // field widths of a management frame
   localparam int FLD_W  = 5;
   localparam int OP_W   = 2;
   localparam int TYP_W  = 2;
   localparam int DAT_W  = 16;
   localparam int HOST_W = 32;

   // frame type codes carried in the command word
   localparam logic [TYP_W-1:0] TYP_C45 = 2'd0;
   localparam logic [TYP_W-1:0] TYP_C22 = 2'd1;

   // Clause 45 opcode that carries the register address
   localparam logic [OP_W-1:0] OP45_ADR = 2'd0;

   // command word layout, bit 13 down to bit 0
   typedef struct packed {
      logic [TYP_W-1:0] typ;
      logic [OP_W-1:0]  op;
      logic [FLD_W-1:0] port;
      logic [FLD_W-1:0] dev;
   } cmd_t;

   localparam int CMD_W  = $bits(cmd_t);
   localparam int GO_BIT = CMD_W;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);

   logic tick;
   logic mdc_q;

   if (DIV_HALF < 1) begin : g_bad_div
      $error("mdio_clkgen: DIV_HALF must be at least 1");
   end

   if (DIV_HALF == 1) begin : g_fast
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CNT_W = $clog2(DIV_HALF);
      localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DIV_HALF - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (cnt_q == CNT_END)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == CNT_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mdc_q <= 1'b0;
      else if (tick)
         mdc_q <= ~mdc_q;
   end

   assign mdc      = mdc_q;
   assign rise_stb = tick & ~mdc_q;
   assign fall_stb = tick &  mdc_q;

   AST_MDC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(mdc_q)); // R10

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
   import mdio_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [REG_AW-1:0]  addr,
   input  logic [HOST_W-1:0]  wdata,
   input  logic               busy,
   input  logic               fin,
   input  logic               fin_rd,
   input  logic               rd_fail,
   input  logic [DAT_W-1:0]   rx_data,
   output logic               launch,
   output cmd_t               cmd_new,
   output logic [DAT_W-1:0]   adr_val,
   output logic [DAT_W-1:0]   wdt_val,
   output logic [HOST_W-1:0]  rdata
);

   cmd_t             cmd_q;
   logic [DAT_W-1:0] adr_q;
   logic [DAT_W-1:0] wdt_q;
   logic [DAT_W-1:0] rdt_q;
   logic             sts_q;
   logic             cmd_wr;
   logic             unused_wdata;

   assign unused_wdata = ^wdata[HOST_W-1:DAT_W];

   assign cmd_wr  = wr && (addr == OFS_CMD);
   assign launch  = cmd_wr && wdata[GO_BIT] && !busy;
   assign cmd_new = cmd_t'(wdata[CMD_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         adr_q <= '0;
         wdt_q <= '0;
         rdt_q <= '0;
         sts_q <= 1'b0;
      end else begin
         if (cmd_wr && !busy)
            cmd_q <= cmd_new;
         if (wr && (addr == OFS_ADR))
            adr_q <= wdata[DAT_W-1:0];
         if (wr && (addr == OFS_WDT))
            wdt_q <= wdata[DAT_W-1:0];
         if (fin && fin_rd) begin
            rdt_q <= rx_data;
            sts_q <= rd_fail;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CMD: rdata = HOST_W'({busy, cmd_q});
         OFS_ADR: rdata = HOST_W'(adr_q);
         OFS_WDT: rdata = HOST_W'(wdt_q);
         OFS_RDT: rdata = HOST_W'(rdt_q);
         OFS_STS: rdata = HOST_W'(sts_q);
         default: rdata = '0;
      endcase
   end

   assign adr_val = adr_q;
   assign wdt_val = wdt_q;

   AST_BUSY_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> $stable(cmd_q)); // R4

   AST_STS_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(fin && fin_rd) |=> $stable(sts_q)); // R9

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  cmd_t             cmd,
   input  logic [DAT_W-1:0] payload,
   input  logic             rise_stb,
   input  logic             fall_stb,
   input  logic             mdio_i,
   output logic             busy,
   output logic             mdio_o,
   output logic             mdio_oe,
   output logic             fin,
   output logic             fin_rd,
   output logic             rd_fail,
   output logic [DAT_W-1:0] rx_data
);

   localparam int FRAME_LEN = PRE_LEN + 2 + OP_W + 2 * FLD_W + 2 + DAT_W;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);
   localparam int TA_POS    = PRE_LEN + 2 + OP_W + 2 * FLD_W;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
   localparam logic [IDX_W-1:0] IDX_CHK  = IDX_W'(TA_POS + 2);

   logic                 busy_q;
   logic                 rd_q;
   logic [IDX_W-1:0]     idx_q;
   logic [FRAME_LEN-1:0] sr_q;
   logic                 mdo_q;
   logic                 oe_q;
   logic                 fail_q;
   logic [DAT_W-1:0]     rx_q;

   logic                 is_rd;
   logic [1:0]           start_pat;
   logic [1:0]           ta_pat;
   logic [DAT_W-1:0]     data_fld;
   logic [FRAME_LEN-1:0] frame_w;

   always_comb begin
      is_rd     = cmd.op[OP_W-1];
      start_pat = (cmd.typ == TYP_C22) ? 2'b01 : 2'b00;
      ta_pat    = is_rd ? 2'b11 : 2'b10;
      data_fld  = is_rd ? {DAT_W{1'b1}} : payload;
      frame_w   = {{PRE_LEN{1'b1}}, start_pat, cmd.op, cmd.port, cmd.dev,
                   ta_pat, data_fld};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         idx_q  <= '0;
         sr_q   <= '0;
         mdo_q  <= 1'b1;
         oe_q   <= 1'b0;
         fail_q <= 1'b0;
         rx_q   <= '0;
      end else if (!busy_q) begin
         if (launch) begin
            busy_q <= 1'b1;
            rd_q   <= is_rd;
            idx_q  <= '0;
            sr_q   <= frame_w;
            fail_q <= 1'b0;
         end
      end else begin
         if (fall_stb) begin
            if (idx_q == IDX_LAST) begin
               busy_q <= 1'b0;
               oe_q   <= 1'b0;
               mdo_q  <= 1'b1;
            end else begin
               mdo_q <= sr_q[FRAME_LEN-1];
               sr_q  <= {sr_q[FRAME_LEN-2:0], 1'b0};
               oe_q  <= !(rd_q && (idx_q >= IDX_TA));
               idx_q <= idx_q + 1'b1;
            end
         end
         if (rise_stb) begin
            if (idx_q == IDX_CHK)
               fail_q <= mdio_i;
            else if (idx_q > IDX_CHK)
               rx_q <= {rx_q[DAT_W-2:0], mdio_i};
         end
      end
   end

   assign busy    = busy_q;
   assign mdio_o  = mdo_q;
   assign mdio_oe = oe_q;
   assign fin     = busy_q && fall_stb && (idx_q == IDX_LAST);
   assign fin_rd  = rd_q;
   assign rd_fail = fail_q;
   assign rx_data = rx_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !oe_q); // R11

   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rd_q && (idx_q > IDX_TA)) |-> !oe_q); // R7

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= IDX_LAST)); // R5

   AST_NO_SHIFT_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall_stb) |=> $stable(idx_q)); // R10

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_HALF = 2,
   parameter int PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [4:0]        host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_master: PRE_LEN must be at least 1");
   end

   logic             rise_stb;
   logic             fall_stb;
   logic             launch;
   cmd_t             cmd_new;
   logic [DAT_W-1:0] adr_val;
   logic [DAT_W-1:0] wdt_val;
   logic [DAT_W-1:0] payload;
   logic             busy;
   logic             fin;
   logic             fin_rd;
   logic             rd_fail;
   logic [DAT_W-1:0] rx_data;

   mdio_clkgen #(
      .DIV_HALF (DIV_HALF)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_regfile u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (host_wr),
      .addr    (host_addr),
      .wdata   (host_wdata),
      .busy    (busy),
      .fin     (fin),
      .fin_rd  (fin_rd),
      .rd_fail (rd_fail),
      .rx_data (rx_data),
      .launch  (launch),
      .cmd_new (cmd_new),
      .adr_val (adr_val),
      .wdt_val (wdt_val),
      .rdata   (host_rdata)
   );

   // Clause 45 address frames carry the address word, others the write data
   assign payload = ((cmd_new.typ != TYP_C22) && (cmd_new.op == OP45_ADR)) ?
                    adr_val : wdt_val;

   mdio_shifter #(
      .PRE_LEN (PRE_LEN)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .cmd      (cmd_new),
      .payload  (payload),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .fin      (fin),
      .fin_rd   (fin_rd),
      .rd_fail  (rd_fail),
      .rx_data  (rx_data)
   );

   AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(mdc) |-> $stable(mdio_o)); // R10

   AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(mdc) |-> $stable(mdio_oe)); // R10

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

   localparam int CLK_NS   = 10;
   localparam int DIV      = 2;
   localparam int NVEC     = 7;

   localparam logic [4:0] A_CMD = 5'h00;
   localparam logic [4:0] A_ADR = 5'h04;
   localparam logic [4:0] A_WDT = 5'h08;
   localparam logic [4:0] A_RDT = 5'h0C;
   localparam logic [4:0] A_STS = 5'h10;

   typedef struct packed {
      logic [1:0]  typ;
      logic [1:0]  op;
      logic [4:0]  phy;
      logic [4:0]  dev;
      logic [15:0] adr;
      logic [15:0] wdt;
      logic [15:0] resp;
      logic        ack;
   } vec_t;

   localparam logic [62:0] VECS [0:NVEC-1] = '{
      {2'd1, 2'd1, 5'd3,  5'h11, 16'h0000, 16'hA5C3, 16'h0000, 1'b0},
      {2'd1, 2'd2, 5'h1F, 5'h02, 16'h0000, 16'h0000, 16'h1234, 1'b1},
      {2'd1, 2'd2, 5'd0,  5'h05, 16'h0000, 16'h0000, 16'h7777, 1'b0},
      {2'd0, 2'd0, 5'h0A, 5'h07, 16'hBEEF, 16'h0000, 16'h0000, 1'b0},
      {2'd0, 2'd1, 5'h15, 5'h1E, 16'h1111, 16'h8001, 16'h0000, 1'b0},
      {2'd0, 2'd2, 5'd1,  5'h03, 16'h0000, 16'h0000, 16'hFEDC, 1'b1},
      {2'd0, 2'd3, 5'd2,  5'h01, 16'h0000, 16'h0000, 16'h0F0F, 1'b1}
   };

   logic        clk;
   logic        rst_n;
   logic        host_wr;
   logic [4:0]  host_addr;
   logic [31:0] host_wdata;
   logic [31:0] host_rdata;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i;

   int checks = 0;
   int errors = 0;

   // PHY responder state
   logic [63:0] cap;
   logic [63:0] capoe;
   int          k = 0;
   bit          in_frame = 0;
   int          frames = 0;
   logic        phy_oe = 1'b0;
   logic        phy_val = 1'b1;
   logic [15:0] resp_data = 16'h0;
   bit          resp_ack = 0;

   assign mdio_i = phy_oe ? phy_val : 1'b1;

   mdio_master #(.DIV_HALF(DIV), .PRE_LEN(32)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .mdc        (mdc),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .mdio_i     (mdio_i)
   );

   initial clk = 1'b0;
   always #(CLK_NS / 2) clk = ~clk;

   always @(posedge mdc) begin
      if (!in_frame && mdio_oe) begin
         in_frame = 1;
         k = 0;
         cap = '0;
         capoe = '0;
      end
      if (in_frame) begin
         cap[63-k]   = mdio_o;
         capoe[63-k] = mdio_oe;
         k = k + 1;
         if (k == 64) begin
            in_frame = 0;
            frames = frames + 1;
         end
      end
   end

   // cap[29] holds opcode bit 11 (frame bit 34)
   always @(negedge mdc) begin
      if (in_frame && cap[29] && k >= 47 && k <= 63) begin
         phy_oe  = resp_ack;
         phy_val = (k == 47) ? 1'b0 : resp_data[63-k];
      end else begin
         phy_oe  = 1'b0;
         phy_val = 1'b1;
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr    = 1'b1;
      host_addr  = a;
      host_wdata = d;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 4000; i++) begin
         read_reg(A_CMD, v);
         if (!v[14]) return;
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic [1:0] typ, input logic [1:0] op,
                                             input logic [4:0] phy, input logic [4:0] dev,
                                             input logic [15:0] data);
      logic rd;
      rd = op[1];
      return {32'hFFFF_FFFF, (typ == 2'd1) ? 2'b01 : 2'b00, op, phy, dev,
              rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : data};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [63:0] ef;
      logic        exp_sts;
      vec_t        vc;
      time         t0;
      time         t1;
      int          fr0;

      host_wr    = 1'b0;
      host_addr  = 5'h0;
      host_wdata = 32'h0;
      rst_n      = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check(mdio_oe == 1'b0, "R1", "oe after reset", 64'(mdio_oe), 64'h0);
      check(mdc == 1'b0, "R1", "mdc after reset", 64'(mdc), 64'h0);
      read_reg(A_CMD, v); check(v == 32'h0, "R1", "cmd reg", 64'(v), 64'h0);
      read_reg(A_RDT, v); check(v == 32'h0, "R1", "rdata reg", 64'(v), 64'h0);
      read_reg(A_STS, v); check(v == 32'h0, "R1", "status reg", 64'(v), 64'h0);

      // R2 register map and field widths
      write_reg(A_ADR, 32'hABCD_1234);
      read_reg(A_ADR, v); check(v == 32'h0000_1234, "R2", "addr low16", 64'(v), 64'h1234);
      write_reg(A_WDT, 32'h5555_AAAA);
      read_reg(A_WDT, v); check(v == 32'h0000_AAAA, "R2", "wdata low16", 64'(v), 64'hAAAA);
      write_reg(A_RDT, 32'h0000_00FF);
      read_reg(A_RDT, v); check(v == 32'h0, "R2", "rdata read-only", 64'(v), 64'h0);
      write_reg(A_STS, 32'h1);
      read_reg(A_STS, v); check(v == 32'h0, "R2", "status read-only", 64'(v), 64'h0);

      // R10 MDC period
      @(posedge mdc); t0 = $time;
      @(posedge mdc); t1 = $time;
      check((t1 - t0) == 2 * DIV * CLK_NS, "R10", "mdc period",
            64'(t1 - t0), 64'(2 * DIV * CLK_NS));

      // vector table walk: R3 R5 R6 R7 R8 R9
      exp_sts = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
         vc = vec_t'(VECS[i]);
         resp_data = vc.resp;
         resp_ack  = vc.ack;
         write_reg(A_ADR, {16'h0, vc.adr});
         write_reg(A_WDT, {16'h0, vc.wdt});
         fr0 = frames;
         write_reg(A_CMD, {17'h0, 1'b1, vc.typ, vc.op, vc.phy, vc.dev});
         read_reg(A_CMD, v);
         check(v[14] == 1'b1, "R3", "busy after launch", 64'(v[14]), 64'h1);
         wait_idle();
         read_reg(A_CMD, v);
         check(v == {17'h0, 1'b0, vc.typ, vc.op, vc.phy, vc.dev}, "R3",
               "cmd readback idle", 64'(v), 64'({vc.typ, vc.op, vc.phy, vc.dev}));
         check(frames == fr0 + 1, "R3", "one frame sent", 64'(frames - fr0), 64'h1);
         ef = exp_frame(vc.typ, vc.op, vc.phy, vc.dev,
                        (vc.typ == 2'd0 && vc.op == 2'd0) ? vc.adr : vc.wdt);
         if (vc.op[1]) begin
            check(cap[63:18] == ef[63:18], "R5", "read header bits",
                  64'(cap[63:18]), 64'(ef[63:18]));
            check(capoe[17:0] == 18'h0, "R7", "read release", 64'(capoe[17:0]), 64'h0);
            exp_sts = !vc.ack;
            read_reg(A_STS, v);
            check(v == 32'(exp_sts), "R9", "status after read", 64'(v), 64'(exp_sts));
            if (vc.ack) begin
               read_reg(A_RDT, v);
               check(v == {16'h0, vc.resp}, "R8", "read data", 64'(v), 64'(vc.resp));
            end
         end else begin
            check(cap == ef, "R6", "write frame bits", cap, ef);
            check(capoe == 64'hFFFF_FFFF_FFFF_FFFF, "R7", "write drive",
                  capoe, 64'hFFFF_FFFF_FFFF_FFFF);
            read_reg(A_STS, v);
            check(v == 32'(exp_sts), "R9", "status kept by write", 64'(v), 64'(exp_sts));
         end
         check(mdio_oe == 1'b0, "R11", "idle release", 64'(mdio_oe), 64'h0);
      end

      // R4 command while busy is ignored
      resp_ack = 0;
      write_reg(A_WDT, 32'h0000_00FF);
      fr0 = frames;
      write_reg(A_CMD, {17'h0, 1'b1, 2'd1, 2'd1, 5'd4, 5'd9});
      write_reg(A_CMD, {17'h0, 1'b1, 2'd0, 2'd3, 5'd7, 5'd2});
      wait_idle();
      ef = exp_frame(2'd1, 2'd1, 5'd4, 5'd9, 16'h00FF);
      check(cap == ef, "R4", "first frame kept", cap, ef);
      read_reg(A_CMD, v);
      check(v == {18'h0, 2'd1, 2'd1, 5'd4, 5'd9}, "R4", "fields unchanged",
            64'(v), 64'({2'd1, 2'd1, 5'd4, 5'd9}));
      repeat (400) @(negedge clk);
      check(frames == fr0 + 1, "R4", "no second frame", 64'(frames - fr0), 64'h1);
      check(mdio_oe == 1'b0, "R11", "released after ignore", 64'(mdio_oe), 64'h0);

      finish_run();
   end

endmodule